// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block stores one incoming frame into a ring of receive descriptors kept in memory that the host shares with it. A frame source pulses a start strobe with the frame's byte count, then supplies the bytes one at a time. The block walks the ring from its receive pointer to find a descriptor that the host has handed over, copies the frame bytes into that entry's buffer, records the received length, and returns the descriptor to the host. It then flags a receive event and, when interrupts are enabled, an interrupt request.

The descriptors and buffers sit behind a synchronous memory port. Reads return one cycle after they are issued, and writes are either a single byte or a 16-bit word. Each descriptor is 8 bytes long: low address word at offset 0, status byte at offset 2, high address byte at offset 3, negative buffer length word at offset 4, and received-byte count word at offset 6. Entry `i` starts at `DESC_BASE + 8*i`. Its buffer starts at `BUF_BASE + i*BUF_BYTES`. The ring has `2**RING_LOG2` entries.

A word write puts `memWdata[7:0]` at `memAddr` and `memWdata[15:8]` at `memAddr+1`. A read returns the byte at `memAddr` in `memRdata[7:0]`.

Top module: `rx_desc_ring_writer`

## Requirements
- R1: After reset the block is idle. `busy`, `byteReady`, `memEn`, `rxEvent` and `irq` are all low, and the receive pointer is at entry 0.
- R2: A descriptor is claimed only when its status byte (offset 2) equals exactly 0x80, which is owned by the block with no flag bits set. A status with any other value, for example 0x83, is skipped.
- R3: The search probes entries in increasing order, modulo the ring size. It starts at the receive pointer and covers every entry except the one just before the pointer. When no entry qualifies, the frame's bytes are consumed, nothing is written, no event is raised, and the pointer does not change.
- R4: On a hit, frame byte `k` is written to `BUF_BASE + i*BUF_BYTES + k`. Bytes with `k >= BUF_BYTES` are consumed but not written, so nothing reaches the next entry's buffer.
- R5: The word at offset 6 of the claimed descriptor receives the frame length plus 4 with its bytes swapped. The high byte of the count lands at offset 6 and the low byte at offset 7.
- R6: The count write is followed in the very next cycle by a byte write of 0x03 to the status byte. After that write the receive pointer is the claimed entry plus one, modulo the ring size.
- R7: `rxEvent` is high for exactly the cycle of the status write. `irq` is high in that same cycle only if `intEnable` is high.
- R8: While `stopMode` is high, a new frame's bytes are consumed with no memory access and no event.
- R9: Start strobes are taken only while idle; a strobe while `busy` is ignored. Counting from the accepting edge, `busy` stays high for the following durations:
  - a hit at the j-th probe (j from 0): 2j+4+L cycles;
  - a frame that finds no descriptor: 2(N-1)+L cycles;
  - a frame arriving while stopped: L cycles.
  Here L is the frame length and N the ring size, with bytes offered every cycle.
- R10: Descriptor reads are single-byte reads of the status byte. Memory is accessed only while `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStart | input | 1 | Start strobe for a new frame |
| frameLen | input | LEN_W | Byte count of the frame, sampled with the strobe |
| stopMode | input | 1 | Discard arriving frames |
| intEnable | input | 1 | Allow the interrupt request |
| byteValid | input | 1 | A frame byte is offered |
| dataByte | input | 8 | Frame byte |
| byteReady | output | 1 | The block takes the offered byte at this edge |
| busy | output | 1 | A frame is in progress |
| memEn | output | 1 | Memory access this cycle |
| memWe | output | 1 | Access is a write |
| memWide | output | 1 | Write is a 16-bit word |
| memAddr | output | ADDR_W | Byte address |
| memWdata | output | 16 | Write data |
| memRdata | input | 16 | Read data, one cycle after the read |
| rxEvent | output | 1 | Frame stored and descriptor returned |
| irq | output | 1 | Interrupt request |

## Verification
Each result has a fixed arrival cycle relative to the edge that accepts the start strobe:
- `busy` rises one cycle after that edge.
- Each probe takes two cycles, because the status read returns one cycle later.
- Data bytes are written in the cycles they are taken.
- The count and status writes take the last two busy cycles, and `rxEvent`/`irq` pulse in the final one.

The bench drives inputs and samples outputs on falling edges. It counts busy cycles against the R9 durations and checks every memory write on the cycle it is issued against a behavioural image of memory. It compares the whole image once the frame is done.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_READ,
    S_CHECK,
    S_DATA,
    S_DRAIN,
    S_COUNT,
    S_STATUS
  } rxState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latch;   // capture length, start scan at pointer
    logic read;    // issue status byte read
    logic step;    // move scan to next entry
    logic take;    // byte taken this edge
    logic store;   // byte may be written to buffer
    logic count;   // write length word
    logic status;  // return descriptor, advance pointer
  } rxCtl_t;

  localparam logic [7:0] STAT_OWNED  = 8'h80;
  localparam logic [7:0] STAT_DONE   = 8'h03;
  localparam int         DESC_STRIDE = 8;
  localparam int         STATUS_OFS  = 2;
  localparam int         COUNT_OFS   = 6;
  localparam int         COUNT_BIAS  = 4;

endpackage

// File: rtl/rx_ring_dp.sv
module rx_ring_dp
  import rx_ring_pkg::*;
#(
  parameter int RING_LOG2 = 2,
  parameter int BUF_BYTES = 16,
  parameter int ADDR_W    = 8,
  parameter int LEN_W     = 16,
  parameter int DESC_BASE = 0,
  parameter int BUF_BASE  = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxCtl_t            ctl,
  input  logic [LEN_W-1:0]  frameLen,
  input  logic [7:0]        dataByte,
  input  logic [15:0]       memRdata,
  output logic              startLenZero,
  output logic              lenZero,
  output logic              statusHit,
  output logic              scanLast,
  output logic              lastByte,
  output logic              memEn,
  output logic              memWe,
  output logic              memWide,
  output logic [ADDR_W-1:0] memAddr,
  output logic [15:0]       memWdata
);
  localparam int RING_N = 1 << RING_LOG2;
  localparam logic [RING_LOG2-1:0] ONE_IDX  = RING_LOG2'(1);
  localparam logic [RING_LOG2-1:0] LAST_TRY = RING_LOG2'(RING_N - 2);
  localparam logic [LEN_W-1:0]     ONE_LEN  = LEN_W'(1);
  localparam logic [LEN_W-1:0]     BUF_LIM  = LEN_W'(BUF_BYTES);

  logic [LEN_W-1:0]     lenReg, byteIdx;
  logic [RING_LOG2-1:0] ringPtr, scanIdx, tries;
  logic [ADDR_W-1:0]    descAddr, bufAddr;
  logic [15:0]          cntVal;
  logic                 inBuf;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lenReg  <= '0;
      byteIdx <= '0;
      ringPtr <= '0;
      scanIdx <= '0;
      tries   <= '0;
    end else begin
      if (ctl.latch) begin
        lenReg  <= frameLen;
        scanIdx <= ringPtr;
        tries   <= '0;
        byteIdx <= '0;
      end
      if (ctl.step) begin
        scanIdx <= scanIdx + ONE_IDX;
        tries   <= tries + ONE_IDX;
      end
      if (ctl.take)   byteIdx <= byteIdx + ONE_LEN;
      if (ctl.status) ringPtr <= scanIdx + ONE_IDX;
    end
  end

  assign descAddr = ADDR_W'(DESC_BASE) + ADDR_W'(scanIdx) * ADDR_W'(DESC_STRIDE);
  assign bufAddr  = ADDR_W'(BUF_BASE) + ADDR_W'(scanIdx) * ADDR_W'(BUF_BYTES)
                  + ADDR_W'(byteIdx);
  assign cntVal   = 16'(lenReg) + 16'(COUNT_BIAS);
  assign inBuf    = byteIdx < BUF_LIM;

  assign startLenZero = (frameLen == '0);
  assign lenZero      = (lenReg == '0);
  assign statusHit    = (memRdata[7:0] == STAT_OWNED);
  assign scanLast     = (tries == LAST_TRY);
  assign lastByte     = (byteIdx == lenReg - ONE_LEN);

  always_comb begin
    memEn    = 1'b0;
    memWe    = 1'b0;
    memWide  = 1'b0;
    memAddr  = descAddr + ADDR_W'(STATUS_OFS);
    memWdata = '0;
    if (ctl.read) begin
      memEn = 1'b1;
    end else if (ctl.store && inBuf) begin
      memEn    = 1'b1;
      memWe    = 1'b1;
      memAddr  = bufAddr;
      memWdata = {8'h00, dataByte};
    end else if (ctl.count) begin
      memEn    = 1'b1;
      memWe    = 1'b1;
      memWide  = 1'b1;
      memAddr  = descAddr + ADDR_W'(COUNT_OFS);
      memWdata = {cntVal[7:0], cntVal[15:8]};
    end else if (ctl.status) begin
      memEn    = 1'b1;
      memWe    = 1'b1;
      memWdata = {8'h00, STAT_DONE};
    end
  end

endmodule

// File: rtl/rx_ring_ctrl.sv
module rx_ring_ctrl
  import rx_ring_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   frameStart,
  input  logic   stopMode,
  input  logic   byteValid,
  input  logic   startLenZero,
  input  logic   lenZero,
  input  logic   statusHit,
  input  logic   scanLast,
  input  logic   lastByte,
  output rxCtl_t ctl,
  output logic   busy,
  output logic   byteReady,
  output logic   rxEvent
);
  rxState_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    ctl       = '0;
    byteReady = 1'b0;
    rxEvent   = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (frameStart) begin
          ctl.latch = 1'b1;
          if (stopMode) nextState = startLenZero ? S_IDLE : S_DRAIN;
          else          nextState = S_READ;
        end
      end
      S_READ: begin
        ctl.read  = 1'b1;
        nextState = S_CHECK;
      end
      S_CHECK: begin
        if (statusHit)     nextState = lenZero ? S_COUNT : S_DATA;
        else if (scanLast) nextState = lenZero ? S_IDLE : S_DRAIN;
        else begin
          ctl.step  = 1'b1;
          nextState = S_READ;
        end
      end
      S_DATA: begin
        byteReady = 1'b1;
        if (byteValid) begin
          ctl.take  = 1'b1;
          ctl.store = 1'b1;
          if (lastByte) nextState = S_COUNT;
        end
      end
      S_DRAIN: begin
        byteReady = 1'b1;
        if (byteValid) begin
          ctl.take = 1'b1;
          if (lastByte) nextState = S_IDLE;
        end
      end
      S_COUNT: begin
        ctl.count = 1'b1;
        nextState = S_STATUS;
      end
      S_STATUS: begin
        ctl.status = 1'b1;
        rxEvent    = 1'b1;
        nextState  = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  assign busy = (state != S_IDLE);

endmodule

// File: rtl/rx_desc_ring_writer.sv
module rx_desc_ring_writer
  import rx_ring_pkg::*;
#(
  parameter int RING_LOG2 = 2,
  parameter int BUF_BYTES = 16,
  parameter int ADDR_W    = 8,
  parameter int LEN_W     = 16,
  parameter int DESC_BASE = 0,
  parameter int BUF_BASE  = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameStart,
  input  logic [LEN_W-1:0]  frameLen,
  input  logic              stopMode,
  input  logic              intEnable,
  input  logic              byteValid,
  input  logic [7:0]        dataByte,
  output logic              byteReady,
  output logic              busy,
  output logic              memEn,
  output logic              memWe,
  output logic              memWide,
  output logic [ADDR_W-1:0] memAddr,
  output logic [15:0]       memWdata,
  input  logic [15:0]       memRdata,
  output logic              rxEvent,
  output logic              irq
);
  rxCtl_t ctl;
  logic   startLenZero, lenZero, statusHit, scanLast, lastByte;

  rx_ring_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .stopMode(stopMode),
    .byteValid(byteValid), .startLenZero(startLenZero), .lenZero(lenZero),
    .statusHit(statusHit), .scanLast(scanLast), .lastByte(lastByte),
    .ctl(ctl), .busy(busy), .byteReady(byteReady), .rxEvent(rxEvent)
  );

  rx_ring_dp #(
    .RING_LOG2(RING_LOG2), .BUF_BYTES(BUF_BYTES), .ADDR_W(ADDR_W),
    .LEN_W(LEN_W), .DESC_BASE(DESC_BASE), .BUF_BASE(BUF_BASE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .frameLen(frameLen),
    .dataByte(dataByte), .memRdata(memRdata),
    .startLenZero(startLenZero), .lenZero(lenZero), .statusHit(statusHit),
    .scanLast(scanLast), .lastByte(lastByte),
    .memEn(memEn), .memWe(memWe), .memWide(memWide),
    .memAddr(memAddr), .memWdata(memWdata)
  );

  assign irq = rxEvent & intEnable;

endmodule

// File: rtl/rx_desc_ring_writer_chk.sv
module rx_desc_ring_writer_chk (
  input logic        clk,
  input logic        rstN,
  input logic        frameStart,
  input logic        stopMode,
  input logic        intEnable,
  input logic        busy,
  input logic        byteReady,
  input logic        memEn,
  input logic        memWe,
  input logic        memWide,
  input logic [15:0] memWdata,
  input logic        rxEvent,
  input logic        irq
);
  assert_status_after_count_R6: assert property (@(posedge clk) disable iff (!rstN)
    memEn && memWe && memWide |=> memEn && memWe && !memWide
                                  && memWdata[7:0] == 8'h03 && rxEvent);

  assert_event_ends_frame_R7: assert property (@(posedge clk) disable iff (!rstN)
    rxEvent |=> !busy);

  assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> rxEvent && intEnable);

  assert_stop_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    !busy && frameStart && stopMode |=> !memEn);

  assert_ready_only_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    byteReady |-> busy);

  assert_access_only_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    memEn |-> busy);

  assert_byte_reads_R10: assert property (@(posedge clk) disable iff (!rstN)
    memEn && !memWe |-> !memWide);
endmodule

bind rx_desc_ring_writer rx_desc_ring_writer_chk u_chk (.*);

// File: tb/rx_desc_ring_writer_bench.sv
module rx_desc_ring_writer_bench;
  localparam int N   = 4;
  localparam int BUF = 16;
  localparam int DB  = 0;
  localparam int BB  = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameStart = 1'b0;
  logic [15:0] frameLen = '0;
  logic        stopMode = 1'b0;
  logic        intEnable = 1'b0;
  logic        byteValid = 1'b1;
  logic [7:0]  dataByte = '0;
  logic        byteReady, busy, memEn, memWe, memWide, rxEvent, irq;
  logic [7:0]  memAddr;
  logic [15:0] memWdata;
  logic [15:0] memRdata = '0;

  logic [7:0] mem [0:255];
  logic [7:0] expMem [0:255];
  logic       tbWr = 1'b0;
  logic [7:0] tbAddr = '0, tbData = '0;
  int         expPtr = 0;
  int         checks = 0, errors = 0;

  always #10 clk = ~clk;

  rx_desc_ring_writer u_rx_desc_ring_writer (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .frameLen(frameLen),
    .stopMode(stopMode), .intEnable(intEnable), .byteValid(byteValid),
    .dataByte(dataByte), .byteReady(byteReady), .busy(busy), .memEn(memEn),
    .memWe(memWe), .memWide(memWide), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .rxEvent(rxEvent), .irq(irq)
  );

  // memory slave with one-cycle read latency
  always @(posedge clk) begin
    if (!rstN) begin
      for (int a = 0; a < 256; a++) mem[a] <= 8'hEE;
    end else if (tbWr) begin
      mem[tbAddr] <= tbData;
    end else if (memEn) begin
      if (memWe) begin
        mem[memAddr] <= memWdata[7:0];
        if (memWide) mem[memAddr + 8'd1] <= memWdata[15:8];
      end else begin
        memRdata <= {mem[memAddr + 8'd1], mem[memAddr]};
      end
    end
  end

  // every write checked in the cycle it is issued (R4 R5 R6)
  always @(negedge clk) begin
    if (rstN && memEn && memWe) begin
      checks++;
      if (memWdata[7:0] !== expMem[memAddr] ||
          (memWide && memWdata[15:8] !== expMem[memAddr + 8'd1])) begin
        errors++;
        $display("FAIL R4/R5/R6 write addr %0d: actual %h expected %h%h",
                 memAddr, memWdata, expMem[memAddr + 8'd1], expMem[memAddr]);
      end
    end
  end

  function automatic logic [7:0] pat(input int tag, input int k);
    return 8'((tag + 3 * k) & 255);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic setStatus(input int idx, input logic [7:0] v);
    @(negedge clk);
    tbWr = 1'b1; tbAddr = 8'(DB + 8 * idx + 2); tbData = v;
    expMem[DB + 8 * idx + 2] = v;
    @(negedge clk);
    tbWr = 1'b0;
  endtask

  task automatic runFrame(input int len, input int tag, input string req, input bit glitch);
    int expBusy, hit, gotBusy, gotEv, gotIrq, k, bad, cnt;
    bit prevTake;
    hit = -1; expBusy = 0;
    if (stopMode) expBusy = len;
    else begin
      for (int j = 0; j < N - 1; j++) begin
        int idx = (expPtr + j) % N;
        if (hit < 0 && expMem[DB + 8 * idx + 2] == 8'h80) begin
          hit = idx; expBusy = 2 * j + 4 + len;
        end
      end
      if (hit < 0) expBusy = 2 * (N - 1) + len;
    end
    if (hit >= 0) begin
      for (int i = 0; i < len && i < BUF; i++) expMem[BB + hit * BUF + i] = pat(tag, i);
      cnt = len + 4;
      expMem[DB + 8 * hit + 6] = 8'(cnt >> 8);
      expMem[DB + 8 * hit + 7] = 8'(cnt);
      expMem[DB + 8 * hit + 2] = 8'h03;
      expPtr = (hit + 1) % N;
    end
    @(negedge clk);
    frameLen = 16'(len); frameStart = 1'b1;
    k = 0; prevTake = 1'b0; dataByte = pat(tag, 0);
    @(negedge clk);
    frameStart = 1'b0;
    gotBusy = 0; gotEv = 0; gotIrq = 0;
    while (busy) begin
      gotBusy++;
      if (rxEvent) gotEv++;
      if (irq) gotIrq++;
      if (prevTake) k++;
      dataByte = pat(tag, k);
      prevTake = byteReady;
      if (glitch && gotBusy == 3) begin
        frameStart = 1'b1; frameLen = 16'(len + 9);
      end else frameStart = 1'b0;
      @(negedge clk);
    end
    frameStart = 1'b0;
    check({req, " R9 busy cycles"}, gotBusy, expBusy);
    check({req, " R7 events"}, gotEv, (hit >= 0) ? 1 : 0);
    check({req, " R7 irq"}, gotIrq, (hit >= 0 && intEnable) ? 1 : 0);
    @(negedge clk);
    bad = 0;
    for (int a = 0; a < 256; a++) if (mem[a] !== expMem[a]) bad++;
    check({req, " memory image mismatches"}, bad, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int a = 0; a < 256; a++) expMem[a] = 8'hEE;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 idle outputs", int'({busy, byteReady, memEn, rxEvent, irq}), 0);
    for (int i = 0; i < N; i++) setStatus(i, 8'h80);
    intEnable = 1'b1;
    runFrame(5, 8'h10, "R4 R5 R6 R10 basic hit", 1'b0);
    intEnable = 1'b0;
    runFrame(20, 8'h40, "R4 truncation", 1'b0);
    intEnable = 1'b1;
    setStatus(2, 8'h83);
    runFrame(3, 8'h60, "R2 flagged entry skipped", 1'b0);
    setStatus(3, 8'h80);
    runFrame(4, 8'h70, "R3 no usable entry, slot before pointer excluded", 1'b0);
    stopMode = 1'b1;
    setStatus(0, 8'h80);
    runFrame(6, 8'h90, "R8 stopped", 1'b0);
    stopMode = 1'b0;
    runFrame(0, 8'hA0, "R5 zero length", 1'b0);
    runFrame(7, 8'hB0, "R9 start while busy ignored", 1'b1);
    setStatus(0, 8'h80);
    runFrame(2, 8'hC0, "R6 pointer wrap", 1'b0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule